// File: doc/BRIEF.md
# Branch Condition Evaluator

This combinational block tests a four-bit condition selector against the processor's negative (N), zero (Z), overflow (V) and carry (C) flags. It produces every outcome that three instruction families need. The conditional branch takes its jump when the condition holds. The decrement-and-branch loop instruction stops when the condition holds. Otherwise it counts a 16-bit counter down and jumps back until the counter wraps to all ones. The set-on-condition instruction fills a destination byte with ones or zeros.

The execute stage drives the condition code, the flags, a mode select and the low word of the loop register in the same cycle, and uses the outputs directly. This block does not fetch branch targets or write registers. A parameter selects one of two equivalent decode structures.

Top module: `branch_cond_eval`

## Requirements
- R1: Unsigned relations use these selector codes: HI=2 is true when C=0 and Z=0; LS=3 is true when C=1 or Z=1; CC=4 is true when C=0; CS=5 is true when C=1.
- R2: Signed relations use these selector codes: GE=12 is true when N equals V; LT=13 is true when N differs from V; GT=14 is GE and Z=0; LE=15 is Z=1 or LT.
- R3: Single-flag tests use these selector codes: NE=6 is true when Z=0; EQ=7 is true when Z=1; VC=8 is true when V=0; VS=9 is true when V=1; PL=10 is true when N=0; MI=11 is true when N=1.
- R4: Code 0 (always) is true and code 1 (never) is false, whatever the flags are.
- R5: The mode select is 0 for branch, 1 for loop, 2 for set and 3 for idle. In branch mode, branch_taken equals cond_true, the counter output equals the counter input, and set_byte is zero.
- R6: In loop mode with the condition true, the loop ends: branch_taken is 0 and the counter output equals the counter input.
- R7: In loop mode with the condition false, the counter output is the counter input minus one, modulo 2^16. branch_taken is 1 unless that result is 0xFFFF. An input of 0 therefore falls through.
- R8: In set mode, set_byte is all ones when the condition holds and zero when it does not. branch_taken is 0 and the counter passes through unchanged.
- R9: In idle mode, branch_taken is 0, set_byte is 0 and the counter passes through unchanged. cond_true still reflects the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| op_mode | input | 2 | 0 branch, 1 loop, 2 set, 3 idle |
| loop_cnt_in | input | CNT_W (16) | Low word of the loop counter register |
| cond_true | output | 1 | Selected condition holds |
| branch_taken | output | 1 | Jump to the branch target |
| loop_cnt_out | output | CNT_W (16) | Next value of the loop counter word |
| set_byte | output | SET_W (8) | Byte to write in set mode |

## Verification
The hardest case to reach is the loop fall-through. It needs three things at once: the condition must be false, the counter must be exactly zero, and the decrement must wrap to all ones. Only the never-true code makes the condition false under every flag setting. The bench therefore drives loop mode with counter inputs of 0, 1, 0xFFFF and a middle value under the never-true code, and also under flag-dependent codes that it has forced false. All 256 combinations of selector and flags are also swept against a reference built from the relation definitions. This sweep reaches the signed corners where N and V disagree.

// File: rtl/bce_pkg.sv
package bce_pkg;

   typedef enum logic [1:0] {
      MODE_BRANCH = 2'd0,
      MODE_LOOP   = 2'd1,
      MODE_SET    = 2'd2,
      MODE_IDLE   = 2'd3
   } bce_mode_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } bce_flags_t;

   localparam int CC_W = 4;

endpackage

// File: rtl/bce_cond_decode.sv
module bce_cond_decode
   import bce_pkg::*;
#(
   parameter bit PAIR_DECODE = 1'b1
) (
   input  logic [CC_W-1:0] sel,
   input  bce_flags_t      flags,
   output logic            hit
);

   generate
      if (PAIR_DECODE) begin : g_pair
         // Each odd code is the complement of the even code below it.
         logic base;
         always_comb begin
            case (sel[CC_W-1:1])
               3'd0:    base = 1'b1;
               3'd1:    base = ~flags.c & ~flags.z;
               3'd2:    base = ~flags.c;
               3'd3:    base = ~flags.z;
               3'd4:    base = ~flags.v;
               3'd5:    base = ~flags.n;
               3'd6:    base = ~(flags.n ^ flags.v);
               default: base = ~(flags.n ^ flags.v) & ~flags.z;
            endcase
            hit = base ^ sel[0];
         end
      end else begin : g_full
         always_comb begin
            case (sel)
               4'd0:    hit = 1'b1;
               4'd1:    hit = 1'b0;
               4'd2:    hit = ~flags.c & ~flags.z;
               4'd3:    hit = flags.c | flags.z;
               4'd4:    hit = ~flags.c;
               4'd5:    hit = flags.c;
               4'd6:    hit = ~flags.z;
               4'd7:    hit = flags.z;
               4'd8:    hit = ~flags.v;
               4'd9:    hit = flags.v;
               4'd10:   hit = ~flags.n;
               4'd11:   hit = flags.n;
               4'd12:   hit = ~(flags.n ^ flags.v);
               4'd13:   hit = flags.n ^ flags.v;
               4'd14:   hit = ~(flags.n ^ flags.v) & ~flags.z;
               default: hit = (flags.n ^ flags.v) | flags.z;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/bce_loop_step.sv
module bce_loop_step #(
   parameter int CNT_W = 16
) (
   input  logic             active,
   input  logic             cond_hit,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] cnt_out,
   output logic             take
);

   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_TERM = {CNT_W{1'b1}};

   logic [CNT_W-1:0] dec;
   logic             stepping;

   always_comb begin
      dec      = cnt_in - CNT_ONE;
      stepping = active & ~cond_hit;
      cnt_out  = stepping ? dec : cnt_in;
      take     = stepping & (dec != CNT_TERM);
   end

endmodule

// File: rtl/bce_set_fill.sv
module bce_set_fill #(
   parameter int SET_W = 8
) (
   input  logic             active,
   input  logic             cond_hit,
   output logic [SET_W-1:0] fill
);

   always_comb fill = {SET_W{active & cond_hit}};

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import bce_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SET_W       = 8,
   parameter bit PAIR_DECODE = 1'b1
) (
   input  logic [3:0]       cond_sel,
   input  logic             flag_n,
   input  logic             flag_z,
   input  logic             flag_v,
   input  logic             flag_c,
   input  logic [1:0]       op_mode,
   input  logic [CNT_W-1:0] loop_cnt_in,
   output logic             cond_true,
   output logic             branch_taken,
   output logic [CNT_W-1:0] loop_cnt_out,
   output logic [SET_W-1:0] set_byte
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("branch_cond_eval: CNT_W must be at least 2");
      end
      if (SET_W < 1) begin : g_bad_set
         $error("branch_cond_eval: SET_W must be at least 1");
      end
   endgenerate

   bce_flags_t flags;
   bce_mode_e  mode;
   logic       hit;
   logic       loop_take;

   always_comb begin
      flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
      mode  = bce_mode_e'(op_mode);
   end

   bce_cond_decode #(.PAIR_DECODE(PAIR_DECODE)) u_decode (
      .sel   (cond_sel),
      .flags (flags),
      .hit   (hit)
   );

   bce_loop_step #(.CNT_W(CNT_W)) u_loop (
      .active   (mode == MODE_LOOP),
      .cond_hit (hit),
      .cnt_in   (loop_cnt_in),
      .cnt_out  (loop_cnt_out),
      .take     (loop_take)
   );

   bce_set_fill #(.SET_W(SET_W)) u_set (
      .active   (mode == MODE_SET),
      .cond_hit (hit),
      .fill     (set_byte)
   );

   always_comb begin
      cond_true = hit;
      case (mode)
         MODE_BRANCH: branch_taken = hit;
         MODE_LOOP:   branch_taken = loop_take;
         default:     branch_taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/branch_cond_eval_chk.sv
module branch_cond_eval_chk #(
   parameter int CNT_W = 16,
   parameter int SET_W = 8
) (
   input logic [3:0]       cond_sel,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_v,
   input logic             flag_c,
   input logic [1:0]       op_mode,
   input logic [CNT_W-1:0] loop_cnt_in,
   input logic             cond_true,
   input logic             branch_taken,
   input logic [CNT_W-1:0] loop_cnt_out,
   input logic [SET_W-1:0] set_byte
);

   logic known;

   always_comb begin
      known = !$isunknown({cond_sel, flag_n, flag_z, flag_v, flag_c, op_mode, loop_cnt_in});
      if (known) begin
         // R4
         if (cond_sel == 4'd0) begin
            always_true_chk: assert (cond_true);
         end
         // R4
         if (cond_sel == 4'd1) begin
            never_true_chk: assert (!cond_true);
         end
         // R5
         if (op_mode == 2'd0) begin
            branch_follow_chk: assert (branch_taken == cond_true && loop_cnt_out == loop_cnt_in);
         end
         // R6
         if (op_mode == 2'd1 && cond_true) begin
            loop_exit_chk: assert (!branch_taken && loop_cnt_out == loop_cnt_in);
         end
         // R7
         if (op_mode == 2'd1 && !cond_true) begin
            loop_count_chk: assert (loop_cnt_out + 1'b1 == loop_cnt_in);
         end
         // R7
         if (op_mode == 2'd1 && loop_cnt_in == '0) begin
            loop_fallthru_chk: assert (!branch_taken);
         end
         // R8
         if (op_mode == 2'd2) begin
            set_fill_chk: assert (set_byte == (cond_true ? {SET_W{1'b1}} : '0) && !branch_taken);
         end
         // R9
         if (op_mode == 2'd3) begin
            idle_quiet_chk: assert (!branch_taken && set_byte == '0 && loop_cnt_out == loop_cnt_in);
         end
      end
   end

endmodule

bind branch_cond_eval branch_cond_eval_chk #(.CNT_W(CNT_W), .SET_W(SET_W)) u_chk (.*);

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb;

   logic        clk = 1'b0;
   logic [3:0]  cond_sel;
   logic        flag_n, flag_z, flag_v, flag_c;
   logic [1:0]  op_mode;
   logic [15:0] loop_cnt_in;
   logic        cond_true, branch_taken;
   logic [15:0] loop_cnt_out;
   logic [7:0]  set_byte;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;

   always #5 clk = ~clk;

   branch_cond_eval u_dut (.*);

   function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
      logic n, z, v, cy;
      {n, z, v, cy} = f;
      case (c)
         4'd0:  return 1'b1;
         4'd1:  return 1'b0;
         4'd2:  return !cy && !z;
         4'd3:  return cy || z;
         4'd4:  return !cy;
         4'd5:  return cy;
         4'd6:  return !z;
         4'd7:  return z;
         4'd8:  return !v;
         4'd9:  return v;
         4'd10: return !n;
         4'd11: return n;
         4'd12: return n == v;
         4'd13: return n != v;
         4'd14: return (n == v) && !z;
         default: return z || (n != v);
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic [3:0] c, input logic [3:0] f, input logic [15:0] cnt);
      @(negedge clk);
      op_mode = m; cond_sel = c; {flag_n, flag_z, flag_v, flag_c} = f; loop_cnt_in = cnt;
      #1;
   endtask

   task automatic t_reset_state();
      drive(2'd0, 4'd0, 4'h0, 16'h0000);
      chk("R5 initial taken", {31'd0, branch_taken}, 32'd1);
      chk("R5 initial cnt", {16'd0, loop_cnt_out}, 32'd0);
      chk("R5 initial set", {24'd0, set_byte}, 32'd0);
   endtask

   task automatic t_sweep(input int lo, input int hi, input string req);
      int bad = 0;
      for (int c = lo; c <= hi; c++) begin
         for (int f = 0; f < 16; f++) begin
            drive(2'd0, c[3:0], f[3:0], 16'h1234);
            if (cond_true !== ref_cond(c[3:0], f[3:0])) begin
               bad++;
               $display("FAIL %s: code %0d flags %0h actual %0b expected %0b",
                        req, c, f, cond_true, ref_cond(c[3:0], f[3:0]));
            end
         end
      end
      n_checks++;
      if (bad != 0) n_fail++;
   endtask

   task automatic t_branch();
      drive(2'd0, 4'd7, 4'b0100, 16'hBEEF);
      chk("R5 taken EQ", {31'd0, branch_taken}, 32'd1);
      chk("R5 cnt pass", {16'd0, loop_cnt_out}, 32'hBEEF);
      drive(2'd0, 4'd7, 4'b0000, 16'hBEEF);
      chk("R5 not taken", {31'd0, branch_taken}, 32'd0);
      chk("R5 set zero", {24'd0, set_byte}, 32'd0);
   endtask

   task automatic t_loop_true();
      drive(2'd1, 4'd0, 4'h0, 16'h0005);
      chk("R6 no branch T", {31'd0, branch_taken}, 32'd0);
      chk("R6 cnt hold T", {16'd0, loop_cnt_out}, 32'h0005);
      drive(2'd1, 4'd13, 4'b1000, 16'h0000);
      chk("R6 no branch LT", {31'd0, branch_taken}, 32'd0);
      chk("R6 cnt hold LT", {16'd0, loop_cnt_out}, 32'h0000);
   endtask

   task automatic t_loop_count();
      drive(2'd1, 4'd1, 4'hF, 16'h0005);
      chk("R7 dec 5", {16'd0, loop_cnt_out}, 32'h0004);
      chk("R7 branch 5", {31'd0, branch_taken}, 32'd1);
      drive(2'd1, 4'd1, 4'h0, 16'h0001);
      chk("R7 dec 1", {16'd0, loop_cnt_out}, 32'h0000);
      chk("R7 branch 1", {31'd0, branch_taken}, 32'd1);
      drive(2'd1, 4'd1, 4'h0, 16'h0000);
      chk("R7 wrap 0", {16'd0, loop_cnt_out}, 32'hFFFF);
      chk("R7 fallthru 0", {31'd0, branch_taken}, 32'd0);
      drive(2'd1, 4'd1, 4'h0, 16'hFFFF);
      chk("R7 dec FFFF", {16'd0, loop_cnt_out}, 32'hFFFE);
      chk("R7 branch FFFF", {31'd0, branch_taken}, 32'd1);
      drive(2'd1, 4'd7, 4'b0000, 16'h0000);
      chk("R7 EQ false wrap", {16'd0, loop_cnt_out}, 32'hFFFF);
      chk("R7 EQ false fallthru", {31'd0, branch_taken}, 32'd0);
      drive(2'd1, 4'd14, 4'b0100, 16'h8000);
      chk("R7 GT false dec", {16'd0, loop_cnt_out}, 32'h7FFF);
      chk("R7 GT false branch", {31'd0, branch_taken}, 32'd1);
   endtask

   task automatic t_set();
      drive(2'd2, 4'd5, 4'b0001, 16'h00AA);
      chk("R8 set ones", {24'd0, set_byte}, 32'hFF);
      chk("R8 no branch", {31'd0, branch_taken}, 32'd0);
      chk("R8 cnt pass", {16'd0, loop_cnt_out}, 32'h00AA);
      drive(2'd2, 4'd5, 4'b0000, 16'h00AA);
      chk("R8 set zero", {24'd0, set_byte}, 32'h00);
      drive(2'd2, 4'd0, 4'h0, 16'h0);
      chk("R8 always set", {24'd0, set_byte}, 32'hFF);
      drive(2'd2, 4'd1, 4'hF, 16'h0);
      chk("R8 never set", {24'd0, set_byte}, 32'h00);
   endtask

   task automatic t_idle();
      drive(2'd3, 4'd0, 4'h0, 16'h0000);
      chk("R9 no branch", {31'd0, branch_taken}, 32'd0);
      chk("R9 set zero", {24'd0, set_byte}, 32'd0);
      chk("R9 cnt pass", {16'd0, loop_cnt_out}, 32'h0000);
      chk("R9 cond visible", {31'd0, cond_true}, 32'd1);
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      op_mode = 2'd0; cond_sel = 4'd0; {flag_n, flag_z, flag_v, flag_c} = 4'h0; loop_cnt_in = 16'h0;
      t_reset_state();
      t_sweep(0, 1, "R4");
      t_sweep(2, 5, "R1");
      t_sweep(6, 11, "R3");
      t_sweep(12, 15, "R2");
      t_branch();
      t_loop_true();
      t_loop_count();
      t_set();
      t_idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule